// File: doc/BRIEF.md
# Two-Thread Back-End Entry Allocator

This block sits at the allocation stage of a core that runs two hardware threads over one shared set of back-end buffers: a reorder buffer, a load buffer and a store buffer. Each thread presents micro-ops through its own valid/ready input, and each micro-op carries a three-bit need mask. The block accepts at most one micro-op per cycle. For every buffer the micro-op needs, it reserves the lowest-numbered free entry. It then reports the chosen entry numbers and the owning thread one cycle later.

Each thread may hold no more than half of each buffer at once. A thread that runs into its share on a buffer it needs waits, and the other thread keeps being served. When both threads can be served, they take turns. When only one can be served, that thread gets every cycle. Entries come back through one release input per buffer. Each release is tagged with the entry number and the owning thread.

Top module: `dual_thread_alloc`

## Requirements
- R1: After reset no output is valid and every buffer is empty. On the first cycle in which both threads are eligible, thread 0 is served.
- R2: When both threads are eligible in consecutive cycles, the served thread alternates. At most one thread sees ready in any cycle.
- R3: When exactly one thread is eligible, it is served in that cycle. A thread is only served while its valid is high.
- R4: A thread whose occupancy of any buffer its micro-op needs equals its share is not served, while the other thread continues to be served.
- R5: Each thread's share is half of each buffer's size. With the default sizes of 126, 48 and 24 entries, the shares are 63, 24 and 12.
- R6: Need mask bit 0 selects the reorder buffer, bit 1 the load buffer and bit 2 the store buffer. For each selected buffer, the lowest-index free entry is reserved.
- R7: A release frees the named entry and lowers the named thread's occupancy of that buffer by one. A release and an allocation in the same cycle net correctly. A freed entry becomes available on the next cycle.
- R8: The turn passes to the thread that was not served. If one thread is blocked while the other is served, the blocked thread is served first once it becomes eligible.
- R9: One cycle after a micro-op is accepted, out_valid is high and the outputs carry the thread and the reserved entry numbers. Entry outputs for buffers the micro-op did not need read zero. In a cycle with no acceptance, out_valid is low the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| t0_valid | input | 1 | Thread 0 micro-op present |
| t0_need | input | 3 | Thread 0 need mask (bit0 reorder, bit1 load, bit2 store) |
| t0_ready | output | 1 | Thread 0 micro-op accepted this cycle |
| t1_valid | input | 1 | Thread 1 micro-op present |
| t1_need | input | 3 | Thread 1 need mask |
| t1_ready | output | 1 | Thread 1 micro-op accepted this cycle |
| rel_rob_valid | input | 1 | Reorder entry release |
| rel_rob_tid | input | 1 | Thread owning released reorder entry |
| rel_rob_idx | input | 7 | Released reorder entry |
| rel_ld_valid | input | 1 | Load entry release |
| rel_ld_tid | input | 1 | Thread owning released load entry |
| rel_ld_idx | input | 6 | Released load entry |
| rel_st_valid | input | 1 | Store entry release |
| rel_st_tid | input | 1 | Thread owning released store entry |
| rel_st_idx | input | 5 | Released store entry |
| out_valid | output | 1 | Allocation result valid |
| out_tid | output | 1 | Thread of the allocated micro-op |
| out_rob_idx | output | 7 | Reserved reorder entry, zero if not needed |
| out_ld_idx | output | 6 | Reserved load entry, zero if not needed |
| out_st_idx | output | 5 | Reserved store entry, zero if not needed |

## Verification
The assertions take two things for granted about the release inputs. A release names an entry that is currently held, and the thread tag matches the thread that was granted that entry. One release per buffer per cycle is implicit in the port shape. The stimulus honours this by releasing only entry numbers it has already seen returned on the allocation outputs for that same thread. Given that discipline, the per-thread occupancies always sum to the number of busy entries, so the share and alternation properties can be checked against state alone.

// File: rtl/alloc_pkg.sv
package alloc_pkg;
  typedef enum logic { TH0 = 1'b0, TH1 = 1'b1 } thread_e;
  localparam int NUM_BUF = 3;
  localparam int BUF_ROB = 0;
  localparam int BUF_LD  = 1;
  localparam int BUF_ST  = 2;
endpackage

// File: rtl/entry_pool.sv
module entry_pool #(
  parameter int ENTRIES = 24,
  parameter int SHARE   = ENTRIES / 2,
  localparam int IW = $clog2(ENTRIES),
  localparam int CW = $clog2(SHARE + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take_en,
  input  logic          take_tid,
  input  logic          give_valid,
  input  logic          give_tid,
  input  logic [IW-1:0] give_idx,
  output logic [1:0]    room,
  output logic [IW-1:0] pick_idx
);
  logic [ENTRIES-1:0] busy;
  logic [CW-1:0]      occ [2];
  logic               any_free;

  // lowest-index free entry: scan downward so the last hit wins
  always_comb begin
    any_free = 1'b0;
    pick_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        any_free = 1'b1;
        pick_idx = IW'(i);
      end
    end
  end

  always_comb begin
    for (int t = 0; t < 2; t++) begin
      room[t] = any_free && (occ[t] < CW'(SHARE));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= '0;
    end else begin
      if (take_en)    busy[pick_idx] <= 1'b1;
      if (give_valid) busy[give_idx] <= 1'b0;
    end
  end

  for (genvar t = 0; t < 2; t++) begin : g_occ
    logic inc, dec;
    assign inc = take_en && (take_tid == 1'(t));
    assign dec = give_valid && (give_tid == 1'(t));
    always_ff @(posedge clk) begin
      if (rst) occ[t] <= '0;
      else     occ[t] <= occ[t] + CW'(inc) - CW'(dec);
    end
    AST_SHARE_HELD: assert property (@(posedge clk) disable iff (rst) occ[t] <= CW'(SHARE)); // R4
  end

  AST_OCC_MATCHES_BUSY: assert property (@(posedge clk) disable iff (rst)
    (32'(occ[0]) + 32'(occ[1])) == $countones(busy)); // R7
  AST_TAKE_HAS_ROOM: assert property (@(posedge clk) disable iff (rst)
    take_en |-> room[take_tid]); // R4
  AST_GIVE_HELD: assert property (@(posedge clk) disable iff (rst)
    give_valid |-> (busy[give_idx] && occ[give_tid] != '0)); // R7
endmodule

// File: rtl/turn_arbiter.sv
module turn_arbiter (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] elig,
  output logic [1:0] gnt
);
  logic turn;  // thread preferred when both are eligible

  always_comb begin
    if (elig == 2'b11) gnt = turn ? 2'b10 : 2'b01;
    else               gnt = elig;
  end

  always_ff @(posedge clk) begin
    if (rst)         turn <= 1'b0;
    else if (gnt[0]) turn <= 1'b1;
    else if (gnt[1]) turn <= 1'b0;
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt)); // R2
  AST_SOLO_T0: assert property (@(posedge clk) disable iff (rst)
    (elig == 2'b01) |-> gnt[0]); // R3
  AST_SOLO_T1: assert property (@(posedge clk) disable iff (rst)
    (elig == 2'b10) |-> gnt[1]); // R3
  AST_ALTERNATE: assert property (@(posedge clk) disable iff (rst)
    (elig == 2'b11 && gnt[0]) |=> (elig != 2'b11 || gnt[1])); // R2
  AST_BLOCKED_FIRST: assert property (@(posedge clk) disable iff (rst)
    (elig == 2'b10) |=> (elig != 2'b11 || gnt[0])); // R8
endmodule

// File: rtl/dual_thread_alloc.sv
module dual_thread_alloc
  import alloc_pkg::*;
#(
  parameter int ROB_ENTRIES = 126,
  parameter int LD_ENTRIES  = 48,
  parameter int ST_ENTRIES  = 24,
  localparam int ROB_IW = $clog2(ROB_ENTRIES),
  localparam int LD_IW  = $clog2(LD_ENTRIES),
  localparam int ST_IW  = $clog2(ST_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              t0_valid,
  input  logic [2:0]        t0_need,
  output logic              t0_ready,
  input  logic              t1_valid,
  input  logic [2:0]        t1_need,
  output logic              t1_ready,
  input  logic              rel_rob_valid,
  input  logic              rel_rob_tid,
  input  logic [ROB_IW-1:0] rel_rob_idx,
  input  logic              rel_ld_valid,
  input  logic              rel_ld_tid,
  input  logic [LD_IW-1:0]  rel_ld_idx,
  input  logic              rel_st_valid,
  input  logic              rel_st_tid,
  input  logic [ST_IW-1:0]  rel_st_idx,
  output logic              out_valid,
  output logic              out_tid,
  output logic [ROB_IW-1:0] out_rob_idx,
  output logic [LD_IW-1:0]  out_ld_idx,
  output logic [ST_IW-1:0]  out_st_idx
);
  localparam int ROB_SHARE = ROB_ENTRIES / 2;
  localparam int LD_SHARE  = LD_ENTRIES / 2;
  localparam int ST_SHARE  = ST_ENTRIES / 2;

  logic [1:0]         rob_room, ld_room, st_room;
  logic [ROB_IW-1:0]  rob_pick;
  logic [LD_IW-1:0]   ld_pick;
  logic [ST_IW-1:0]   st_pick;
  logic [NUM_BUF-1:0] need [2];
  logic [1:0]         vld, elig, gnt;
  logic               any_gnt;
  thread_e            sel_tid;
  logic [NUM_BUF-1:0] sel_need, take;

  assign need[0] = t0_need;
  assign need[1] = t1_need;
  assign vld     = {t1_valid, t0_valid};

  for (genvar t = 0; t < 2; t++) begin : g_elig
    logic [NUM_BUF-1:0] room_t;
    assign room_t  = {st_room[t], ld_room[t], rob_room[t]};
    assign elig[t] = vld[t] && ((need[t] & ~room_t) == '0);
  end

  turn_arbiter u_arb (
    .clk (clk),
    .rst (rst),
    .elig(elig),
    .gnt (gnt)
  );

  assign t0_ready = gnt[0];
  assign t1_ready = gnt[1];
  assign any_gnt  = |gnt;
  assign sel_tid  = gnt[1] ? TH1 : TH0;
  assign sel_need = gnt[1] ? t1_need : t0_need;
  assign take     = any_gnt ? sel_need : '0;

  entry_pool #(.ENTRIES(ROB_ENTRIES), .SHARE(ROB_SHARE)) u_rob (
    .clk(clk), .rst(rst),
    .take_en(take[BUF_ROB]), .take_tid(sel_tid),
    .give_valid(rel_rob_valid), .give_tid(rel_rob_tid), .give_idx(rel_rob_idx),
    .room(rob_room), .pick_idx(rob_pick)
  );

  entry_pool #(.ENTRIES(LD_ENTRIES), .SHARE(LD_SHARE)) u_ld (
    .clk(clk), .rst(rst),
    .take_en(take[BUF_LD]), .take_tid(sel_tid),
    .give_valid(rel_ld_valid), .give_tid(rel_ld_tid), .give_idx(rel_ld_idx),
    .room(ld_room), .pick_idx(ld_pick)
  );

  entry_pool #(.ENTRIES(ST_ENTRIES), .SHARE(ST_SHARE)) u_st (
    .clk(clk), .rst(rst),
    .take_en(take[BUF_ST]), .take_tid(sel_tid),
    .give_valid(rel_st_valid), .give_tid(rel_st_tid), .give_idx(rel_st_idx),
    .room(st_room), .pick_idx(st_pick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_tid     <= 1'b0;
      out_rob_idx <= '0;
      out_ld_idx  <= '0;
      out_st_idx  <= '0;
    end else begin
      out_valid   <= any_gnt;
      out_tid     <= sel_tid;
      out_rob_idx <= take[BUF_ROB] ? rob_pick : '0;
      out_ld_idx  <= take[BUF_LD]  ? ld_pick  : '0;
      out_st_idx  <= take[BUF_ST]  ? st_pick  : '0;
    end
  end

  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    (t0_ready |-> t0_valid) and (t1_ready |-> t1_valid)); // R3
endmodule

// File: tb/test_dual_thread_alloc.sv
module test_dual_thread_alloc;
  logic clk = 1'b0;
  logic rst;
  logic t0_valid, t1_valid, t0_ready, t1_ready;
  logic [2:0] t0_need, t1_need;
  logic rel_rob_valid, rel_rob_tid, rel_ld_valid, rel_ld_tid, rel_st_valid, rel_st_tid;
  logic [6:0] rel_rob_idx;
  logic [5:0] rel_ld_idx;
  logic [4:0] rel_st_idx;
  logic out_valid, out_tid;
  logic [6:0] out_rob_idx;
  logic [5:0] out_ld_idx;
  logic [4:0] out_st_idx;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;  // 50 MHz

  dual_thread_alloc i_dual_thread_alloc (
    .clk(clk), .rst(rst),
    .t0_valid(t0_valid), .t0_need(t0_need), .t0_ready(t0_ready),
    .t1_valid(t1_valid), .t1_need(t1_need), .t1_ready(t1_ready),
    .rel_rob_valid(rel_rob_valid), .rel_rob_tid(rel_rob_tid), .rel_rob_idx(rel_rob_idx),
    .rel_ld_valid(rel_ld_valid), .rel_ld_tid(rel_ld_tid), .rel_ld_idx(rel_ld_idx),
    .rel_st_valid(rel_st_valid), .rel_st_tid(rel_st_tid), .rel_st_idx(rel_st_idx),
    .out_valid(out_valid), .out_tid(out_tid),
    .out_rob_idx(out_rob_idx), .out_ld_idx(out_ld_idx), .out_st_idx(out_st_idx)
  );

  // {t0v, t0need, t1v, t1need, exp_valid, exp_tid, exp_rob, exp_ld, exp_st}
  localparam int VW = 28;
  localparam logic [VW-1:0] VEC [8] = '{
    {1'b1, 3'b001, 1'b1, 3'b111, 1'b1, 1'b0, 7'd0, 6'd0, 5'd0},  // R1 thread 0 first
    {1'b1, 3'b001, 1'b1, 3'b111, 1'b1, 1'b1, 7'd1, 6'd0, 5'd0},  // R2
    {1'b1, 3'b001, 1'b1, 3'b111, 1'b1, 1'b0, 7'd2, 6'd0, 5'd0},  // R2
    {1'b1, 3'b001, 1'b1, 3'b111, 1'b1, 1'b1, 7'd3, 6'd1, 5'd1},  // R2 R6
    {1'b1, 3'b010, 1'b0, 3'b111, 1'b1, 1'b0, 7'd0, 6'd2, 5'd0},  // R3 R9
    {1'b1, 3'b100, 1'b0, 3'b000, 1'b1, 1'b0, 7'd0, 6'd0, 5'd2},  // R3
    {1'b0, 3'b111, 1'b0, 3'b111, 1'b0, 1'b0, 7'd0, 6'd0, 5'd0},  // R9 idle
    {1'b0, 3'b000, 1'b1, 3'b001, 1'b1, 1'b1, 7'd4, 6'd0, 5'd0}   // R3
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int cnt;
    t0_valid = 0; t1_valid = 0; t0_need = 0; t1_need = 0;
    rel_rob_valid = 0; rel_rob_tid = 0; rel_rob_idx = 0;
    rel_ld_valid = 0; rel_ld_tid = 0; rel_ld_idx = 0;
    rel_st_valid = 0; rel_st_tid = 0; rel_st_idx = 0;
    do_reset();

    // R1 reset state
    chk("R1 out_valid after reset", 32'(out_valid), 0);
    t0_valid = 1; t0_need = 3'b001; t1_valid = 1; t1_need = 3'b001;
    #1;
    chk("R1 first turn to thread 0", 32'({t1_ready, t0_ready}), 32'b01);
    t0_valid = 0; t1_valid = 0;

    // table walk
    for (int k = 0; k < 8; k++) begin
      logic [VW-1:0] v;
      v = VEC[k];
      @(negedge clk);
      {t0_valid, t0_need, t1_valid, t1_need} = v[27:20];
      #1;
      chk("R2/R3 ready pattern", 32'({t1_ready, t0_ready}),
          v[19] ? (v[18] ? 32'b10 : 32'b01) : 32'b00);
      @(posedge clk);
      @(negedge clk);
      chk("R6/R9 allocation result",
          32'({out_valid, out_tid, out_rob_idx, out_ld_idx, out_st_idx}), 32'(v[19:0]));
      t0_valid = 0; t1_valid = 0;
    end

    // share limit, blocked thread, pointer hand-back
    @(negedge clk);
    do_reset();
    t0_valid = 1; t0_need = 3'b100;
    repeat (12) @(posedge clk);
    @(negedge clk);
    chk("R5 thread 0 last store entry", 32'(out_st_idx), 32'd11);
    #1;
    chk("R4 thread 0 stalled at share 12", 32'(t0_ready), 0);
    t1_valid = 1; t1_need = 3'b100;
    #1;
    chk("R4 other thread served while one blocked", 32'({t1_ready, t0_ready}), 32'b10);
    @(posedge clk);
    @(negedge clk);
    chk("R4 thread 1 takes entry 12", 32'({out_tid, out_st_idx}), 32'({1'b1, 5'd12}));
    rel_st_valid = 1; rel_st_tid = 0; rel_st_idx = 5;
    @(posedge clk);
    @(negedge clk);
    rel_st_valid = 0;
    chk("R7 freed entry not usable same cycle", 32'({out_tid, out_st_idx}), 32'({1'b1, 5'd13}));
    #1;
    chk("R8 unblocked thread served first", 32'({t1_ready, t0_ready}), 32'b01);
    @(posedge clk);
    @(negedge clk);
    chk("R6/R7 lowest freed entry reused", 32'({out_tid, out_st_idx}), 32'({1'b0, 5'd5}));
    t0_valid = 0;

    // same-cycle allocate and release on thread 1
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      if (i == 0) begin
        rel_st_valid = 1; rel_st_tid = 1; rel_st_idx = 12;
      end else begin
        rel_st_valid = 0;
      end
      #1;
      if (t1_ready) cnt++;
      if (i == 1) chk("R6 next free entry 14", 32'(out_st_idx), 32'd14);
      if (i == 2) chk("R7 released entry 12 reused", 32'(out_st_idx), 32'd12);
      @(posedge clk);
      @(negedge clk);
    end
    chk("R7 occupancy nets alloc and release", 32'(cnt), 32'd11);
    t1_valid = 0;

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule